// File: doc/BRIEF.md
# Grouped Vector BFloat16 Max-Number Sequencer

This block runs one grouped vector max-number operation against an external vector register file. A group of two or four consecutive vector registers is paired with one shared source register. Element e of every group register is compared with element e of the shared source, using BFloat16 max-number rules. The results go back into the group registers, overwriting them.

The operation takes four steps. The block reads the shared source once. It then reads each group register in turn and pushes every element through a bank of comparators. All results stay in a local buffer until every group register has been processed, and only then are they written back in ascending register order. Because nothing is written until all operands have been read, the shared source may sit inside the group. A start request made while the feature-enable input is low does no work and raises a one-cycle undefined-instruction flag.

The controller has six named states:
- IDLE: waits for start. It moves to READ_SRC when the feature is enabled, and to UNDEF when it is not.
- READ_SRC: captures the shared source and moves to CALC.
- CALC: handles one group register per cycle. It moves to WRITE after the last one.
- WRITE: writes one result per cycle. It moves to FINISH after the last one.
- FINISH: pulses done and returns to IDLE.
- UNDEF: pulses the undefined flag and returns to IDLE.

Top module: `vgrp_max_seq`

## Requirements
- R1: `grp4` = 0 selects a group of 2 registers and `grp4` = 1 selects 4. Only the group registers are written, and no other register changes.
- R2: The first group register is `base_fld`×2 in the 2-register form. In the 4-register form it is `base_fld[2:0]`×4, and `base_fld[3]` is ignored. Group registers are consecutive.
- R3: The shared source is register {0, `src_fld`}, so only registers 0 to 15 can be selected.
- R4: A vector holds VL/16 elements of 16 bits, and element e occupies bits [16e+15:16e]. Every element of every group register is written, with no masking.
- R5: Negative zero (16'h8000) counts as less than positive zero (16'h0000). When exactly one operand is a quiet NaN (exponent all ones, bit 6 set, non-zero fraction), the result is the other operand.
- R6: Suppose `dflt_nan` was 0 at start, and either operand is a signaling NaN (exponent all ones, bit 6 clear, non-zero fraction) or both operands are NaN. The result is then a quiet NaN, chosen in this order: the group operand with bit 6 set if it is signaling, otherwise the shared operand with bit 6 set if it is signaling, otherwise the group operand.
- R7: In the same NaN cases, when `dflt_nan` was 1 at start, the result is 16'h7FC0.
- R8: `dflt_nan` is sampled on the cycle start is accepted, and later changes do not affect the running operation.
- R9: All results are computed from the register contents present before the first write. Write-back runs in ascending register order, one register per cycle, so a shared source inside the group gives correct results.
- R10: Start with `feat_en` = 0 raises `undef` for exactly one cycle, on the cycle after start. It produces no write and no `done`.
- R11: For a group of n registers, `done` is high for exactly one cycle, 2n+2 cycles after the start edge. It comes on the cycle right after the last write.
- R12: After reset, `done`, `undef` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted in IDLE |
| feat_en | input | 1 | Operation is implemented when high |
| dflt_nan | input | 1 | Default-NaN mode, sampled at start |
| grp4 | input | 1 | 0: two-register group, 1: four-register group |
| base_fld | input | 4 | Scaled group base field |
| src_fld | input | 4 | Shared source register field |
| rd_addr | output | RIDX_W | Register file read index |
| rd_data | input | VL | Register file read data, combinational from rd_addr |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | RIDX_W | Register file write index |
| wr_data | output | VL | Register file write data |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle undefined-instruction pulse |

## Verification
The bench builds two copies of the block side by side: one with VL = 128 (8 lanes) and one with VL = 256 (16 lanes). Both are driven by the same control fields, each with its own register file model. Running both widths shows that the lane generation scales and that the control timing does not depend on VL. The directed NaN and signed-zero cases fill the first 8 lanes, and the wider copy also checks that its upper lanes combine to zero. The table cases place group bases and shared sources so that they overlap, sit at register 31, and set the ignored top bit of the base field.

// File: rtl/vmax_pkg.sv
package vmax_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RDSRC,
        S_CALC,
        S_WRITE,
        S_FIN,
        S_UNDEF
    } seq_st_t;

    localparam logic [15:0] BF_DFLT_NAN = 16'h7FC0;
    localparam int          BF_W        = 16;
    localparam int          GRP_MAX     = 4;

endpackage

// File: rtl/bf16_maxnum.sv
module bf16_maxnum
    import vmax_pkg::*;
(
    input  logic [BF_W-1:0] op_a,
    input  logic [BF_W-1:0] op_b,
    input  logic            dn,
    output logic [BF_W-1:0] res
);

    logic a_nan, b_nan, a_snan, b_snan;
    logic [BF_W-1:0] key_a, key_b;

    always_comb begin
        a_nan  = (op_a[14:7] == 8'hFF) && (op_a[6:0] != 7'd0);
        b_nan  = (op_b[14:7] == 8'hFF) && (op_b[6:0] != 7'd0);
        a_snan = a_nan && !op_a[6];
        b_snan = b_nan && !op_b[6];
        // order-preserving keys: -0 maps just below +0
        key_a  = op_a[15] ? ~op_a : (op_a | 16'h8000);
        key_b  = op_b[15] ? ~op_b : (op_b | 16'h8000);

        if (a_snan || b_snan || (a_nan && b_nan)) begin
            if (dn)          res = BF_DFLT_NAN;
            else if (a_snan) res = op_a | 16'h0040;
            else if (b_snan) res = op_b | 16'h0040;
            else             res = op_a;
        end else if (a_nan) begin
            res = op_b;
        end else if (b_nan) begin
            res = op_a;
        end else begin
            res = (key_a >= key_b) ? op_a : op_b;
        end
    end

endmodule

// File: rtl/vmax_lane_array.sv
module vmax_lane_array
    import vmax_pkg::*;
#(
    parameter int VL = 128
) (
    input  logic [VL-1:0] vec_a,
    input  logic [VL-1:0] vec_b,
    input  logic          dn,
    output logic [VL-1:0] vec_y
);

    localparam int NLANE = VL / BF_W;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        bf16_maxnum u_cmp (
            .op_a (vec_a[e*BF_W +: BF_W]),
            .op_b (vec_b[e*BF_W +: BF_W]),
            .dn   (dn),
            .res  (vec_y[e*BF_W +: BF_W])
        );
    end

endmodule

// File: rtl/vgrp_max_seq.sv
module vgrp_max_seq
    import vmax_pkg::*;
#(
    parameter int VL     = 128,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              feat_en,
    input  logic              dflt_nan,
    input  logic              grp4,
    input  logic [3:0]        base_fld,
    input  logic [3:0]        src_fld,
    output logic [RIDX_W-1:0] rd_addr,
    input  logic [VL-1:0]     rd_data,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_addr,
    output logic [VL-1:0]     wr_data,
    output logic              done,
    output logic              undef
);

    localparam int CNT_W = $clog2(GRP_MAX);

    if (VL % BF_W != 0) begin : g_bad_vl
        $error("VL must be a multiple of 16");
    end

    seq_st_t st, st_nx;

    logic [RIDX_W-1:0] base_q;
    logic [3:0]        src_q;
    logic              g4_q;
    logic              dn_q;
    logic [CNT_W-1:0]  r_q;
    logic              last_r;
    logic [VL-1:0]     src_vec_q;
    logic [VL-1:0]     res_buf [GRP_MAX];
    logic [VL-1:0]     lane_y;
    logic [RIDX_W-1:0] base_nx;

    assign last_r  = (r_q == (g4_q ? CNT_W'(3) : CNT_W'(1)));
    // group base: field scaled by the group size
    assign base_nx = grp4 ? RIDX_W'({base_fld[2:0], 2'b00})
                          : RIDX_W'({base_fld, 1'b0});

    vmax_lane_array #(.VL(VL)) u_lanes (
        .vec_a (rd_data),
        .vec_b (src_vec_q),
        .dn    (dn_q),
        .vec_y (lane_y)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = feat_en ? S_RDSRC : S_UNDEF;
            S_RDSRC: st_nx = S_CALC;
            S_CALC:  if (last_r) st_nx = S_WRITE;
            S_WRITE: if (last_r) st_nx = S_FIN;
            S_FIN:   st_nx = S_IDLE;
            S_UNDEF: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        rd_addr = '0;
        wr_en   = 1'b0;
        wr_addr = base_q + RIDX_W'(r_q);
        wr_data = res_buf[r_q];
        done    = 1'b0;
        undef   = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_RDSRC: rd_addr = RIDX_W'({1'b0, src_q});
            S_CALC:  rd_addr = base_q + RIDX_W'(r_q);
            S_WRITE: wr_en   = 1'b1;
            S_FIN:   done    = 1'b1;
            S_UNDEF: undef   = 1'b1;
            default: ;
        endcase
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            src_q  <= '0;
            g4_q   <= 1'b0;
            dn_q   <= 1'b0;
            r_q    <= '0;
        end else begin
            if (st == S_IDLE && start && feat_en) begin
                base_q <= base_nx;
                src_q  <= src_fld;
                g4_q   <= grp4;
                dn_q   <= dflt_nan;
                r_q    <= '0;
            end else if (st == S_CALC || st == S_WRITE) begin
                r_q <= last_r ? '0 : r_q + CNT_W'(1);
            end
        end
    end

    // operand and result storage
    always_ff @(posedge clk) begin
        if (st == S_RDSRC) src_vec_q <= rd_data;
        if (st == S_CALC)  res_buf[r_q] <= lane_y;
    end

endmodule

// File: rtl/vgrp_max_chk.sv
module vgrp_max_chk
    import vmax_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input seq_st_t           st,
    input logic              g4_q,
    input logic [RIDX_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [RIDX_W-1:0] wr_addr,
    input logic              done,
    input logic              undef
);

    assert_src_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RDSRC) |-> (rd_addr[RIDX_W-1] == 1'b0));

    assert_wr_ascend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + RIDX_W'(1)));

    assert_wr_after_calc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(st) == S_CALC || $past(wr_en)));

    assert_wr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (g4_q ? (wr_addr[1:0] == 2'b00) : (wr_addr[0] == 1'b0)));

    assert_done_after_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_undef_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!wr_en && !done));

endmodule

bind vgrp_max_seq vgrp_max_chk #(.RIDX_W(RIDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .g4_q    (g4_q),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (done),
    .undef   (undef)
);

// File: tb/sim_vgrp_max_seq.sv
module sim_vgrp_max_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int VA  = 128;
    localparam int VB  = 256;
    localparam int NEA = VA / 16;
    localparam int NEB = VB / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, feat = 1'b0, g4 = 1'b0, dn = 1'b0;
    logic [3:0] bf = '0, sf = '0;

    logic [4:0]    rda, rdb, wa, wb;
    logic [VA-1:0] rd_a, wd_a;
    logic [VB-1:0] rd_b, wd_b;
    logic          wea, web, done_a, done_b, ua, ub;

    logic [VA-1:0] rf_a [32];
    logic [VA-1:0] ex_a [32];
    logic [VB-1:0] rf_b [32];
    logic [VB-1:0] ex_b [32];

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign rd_a = rf_a[rda];
    assign rd_b = rf_b[rdb];

    always @(posedge clk) if (wea) rf_a[wa] = wd_a;
    always @(posedge clk) if (web) rf_b[wb] = wd_b;

    vgrp_max_seq #(.VL(VA)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat), .dflt_nan(dn),
        .grp4(g4), .base_fld(bf), .src_fld(sf), .rd_addr(rda), .rd_data(rd_a),
        .wr_en(wea), .wr_addr(wa), .wr_data(wd_a), .done(done_a), .undef(ua)
    );

    vgrp_max_seq #(.VL(VB)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat), .dflt_nan(dn),
        .grp4(g4), .base_fld(bf), .src_fld(sf), .rd_addr(rdb), .rd_data(rd_b),
        .wr_en(web), .wr_addr(wb), .wr_data(wd_b), .done(done_b), .undef(ub)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference max-number, written from the requirements
    function automatic logic [15:0] mref(input logic [15:0] a, input logic [15:0] b, input logic d);
        bit an = (a[14:7] == 8'hFF) && (a[6:0] != 0);
        bit bn = (b[14:7] == 8'hFF) && (b[6:0] != 0);
        bit as = an && (a[6] == 1'b0);
        bit bs = bn && (b[6] == 1'b0);
        if (as || bs || (an && bn)) begin
            if (d) return 16'h7FC0;
            if (as) return {a[15:7], 1'b1, a[5:0]};
            if (bs) return {b[15:7], 1'b1, b[5:0]};
            return a;
        end
        if (an) return b;
        if (bn) return a;
        if (a[15] != b[15]) return a[15] ? b : a;
        if (!a[15]) return (a[14:0] >= b[14:0]) ? a : b;
        return (a[14:0] <= b[14:0]) ? a : b;
    endfunction

    function automatic logic [15:0] gen(input int r, input int e, input int s);
        logic [31:0] h = 32'(r * 7919 + e * 104729 + s * 31337 + 17);
        h = h * 32'h9E3779B1;
        h = h ^ (h >> 13);
        case (h[2:0])
            3'd0: return 16'h0000;
            3'd1: return 16'h8000;
            3'd2: return {h[6], 15'h7FC0 | 15'(h[5:3])};
            3'd3: return {h[6], 8'hFF, 1'b0, h[8:4], 1'b1};
            3'd4: return {h[6], 15'h7F80};
            default: return h[31:16];
        endcase
    endfunction

    task automatic load(input int s);
        for (int r = 0; r < 32; r++) begin
            for (int e = 0; e < NEA; e++) rf_a[r][e*16 +: 16] = gen(r, e, s);
            for (int e = 0; e < NEB; e++) rf_b[r][e*16 +: 16] = gen(r, e, s);
        end
    endtask

    // runs one operation on both widths and compares both register files
    task automatic run_op(input bit f, input bit q4, input bit d, input logic [3:0] b,
                          input logic [3:0] s, input bit flip);
        int base = q4 ? int'(b[2:0]) * 4 : int'(b) * 2;
        int n    = q4 ? 4 : 2;
        int k;
        bit ovl  = (int'(s) >= base) && (int'(s) < base + n);
        for (int r = 0; r < 32; r++) begin
            ex_a[r] = rf_a[r];
            ex_b[r] = rf_b[r];
        end
        if (f) begin
            for (int r = 0; r < n; r++) begin
                for (int e = 0; e < NEA; e++)
                    ex_a[base+r][e*16 +: 16] = mref(rf_a[base+r][e*16 +: 16], rf_a[s][e*16 +: 16], d);
                for (int e = 0; e < NEB; e++)
                    ex_b[base+r][e*16 +: 16] = mref(rf_b[base+r][e*16 +: 16], rf_b[s][e*16 +: 16], d);
            end
        end
        @(negedge clk);
        feat = f; g4 = q4; dn = d; bf = b; sf = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (flip) dn = ~dn;   // R8: must not matter after start
        k = 1;
        while (k < 40 && !(done_a || ua)) begin
            @(negedge clk);
            k++;
        end
        if (f) begin
            check(k == 2*n + 2, "R11", "done latency", 256'(k), 256'(2*n + 2));
            check(done_b == done_a, "R11", "wide copy done", 256'(done_b), 256'(done_a));
        end else begin
            check(k == 1 && ua && ub, "R10", "undef pulse cycle", 256'(k), 256'(1));
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(!done_a && !done_b && !ua, "R10", "no done after undef",
                      256'({done_a, done_b, ua}), 256'(0));
            end
        end
        @(negedge clk);
        for (int r = 0; r < 32; r++) begin
            bit in_g = f && (r >= base) && (r < base + n);
            string tg = !in_g ? "R1/R3" : (ovl ? "R9" : "R2/R4/R6");
            if (!f) tg = "R10";
            check(rf_a[r] == ex_a[r], tg, $sformatf("VL128 reg %0d", r), 256'(rf_a[r]), 256'(ex_a[r]));
            check(rf_b[r] == ex_b[r], tg, $sformatf("VL256 reg %0d", r), 256'(rf_b[r]), 256'(ex_b[r]));
        end
    endtask

    // {feat, grp4, dflt_nan, base_fld, src_fld, seed}
    localparam logic [18:0] TBL [8] = '{
        {1'b1, 1'b0, 1'b0, 4'd3,  4'd2,  8'd1},
        {1'b1, 1'b1, 1'b0, 4'd5,  4'd15, 8'd2},
        {1'b1, 1'b0, 1'b1, 4'd15, 4'd9,  8'd3},
        {1'b1, 1'b1, 1'b1, 4'd13, 4'd4,  8'd4},
        {1'b1, 1'b0, 1'b0, 4'd0,  4'd1,  8'd5},
        {1'b1, 1'b1, 1'b1, 4'd1,  4'd6,  8'd6},
        {1'b0, 1'b1, 1'b0, 4'd2,  4'd3,  8'd7},
        {1'b1, 1'b0, 1'b0, 4'd7,  4'd14, 8'd8}
    };

    // directed lane cases: group operand, shared operand, result for dn=0 / dn=1
    localparam logic [15:0] CA [8] = '{16'h8000, 16'h0000, 16'h7FC0, 16'hC000,
                                       16'h7F81, 16'h7FC2, 16'h3F80, 16'h4000};
    localparam logic [15:0] CB [8] = '{16'h0000, 16'h8000, 16'h3F80, 16'h7FC5,
                                       16'h3F80, 16'hFFC3, 16'hFF85, 16'hC040};
    localparam logic [15:0] CE0 [8] = '{16'h0000, 16'h0000, 16'h3F80, 16'hC000,
                                        16'h7FC1, 16'h7FC2, 16'hFFC5, 16'h4000};
    localparam logic [15:0] CE1 [8] = '{16'h0000, 16'h0000, 16'h3F80, 16'hC000,
                                        16'h7FC0, 16'h7FC0, 16'h7FC0, 16'h4000};

    task automatic corner(input bit d);
        for (int r = 0; r < 32; r++) begin
            rf_a[r] = '0;
            rf_b[r] = '0;
        end
        for (int e = 0; e < 8; e++) begin
            rf_a[6][e*16 +: 16] = CA[e];
            rf_b[6][e*16 +: 16] = CA[e];
            rf_a[2][e*16 +: 16] = CB[e];
            rf_b[2][e*16 +: 16] = CB[e];
        end
        run_op(1'b1, 1'b0, d, 4'd3, 4'd2, 1'b1);
        for (int e = 0; e < 8; e++) begin
            logic [15:0] x = d ? CE1[e] : CE0[e];
            string tg = (e < 4 || e == 7) ? "R5" : (d ? "R7/R8" : "R6/R8");
            check(rf_a[6][e*16 +: 16] == x, tg, $sformatf("lane %0d VL128", e),
                  256'(rf_a[6][e*16 +: 16]), 256'(x));
            check(rf_b[6][e*16 +: 16] == x, tg, $sformatf("lane %0d VL256", e),
                  256'(rf_b[6][e*16 +: 16]), 256'(x));
        end
        for (int e = 8; e < NEB; e++)
            check(rf_b[6][e*16 +: 16] == 16'h0, "R4", $sformatf("upper lane %0d", e),
                  256'(rf_b[6][e*16 +: 16]), 256'(0));
    endtask

    bit fin = 1'b0;

    initial begin
        #(200000 * 5);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        load(0);
        repeat (3) @(negedge clk);
        // R12: outputs quiet in and after reset
        check(!done_a && !ua && !wea && !done_b && !ub && !web, "R12", "reset outputs",
              256'({done_a, ua, wea, done_b, ub, web}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_a && !ua && !wea, "R12", "after reset", 256'({done_a, ua, wea}), 256'(0));

        for (int i = 0; i < 8; i++) begin
            load(int'(TBL[i][7:0]));
            run_op(TBL[i][18], TBL[i][17], TBL[i][16], TBL[i][15:12], TBL[i][11:8], 1'b0);
        end

        corner(1'b0);
        corner(1'b1);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule